// File: doc/BRIEF.md
# Four-Stage Pipelined G Mixer

This block evaluates the G mixing function of a 64-bit keyed hash round. It works on four state words (a, b, c, d) and two message words (x, y). The work is cut into four register-separated steps. Each step performs one add followed by an XOR-and-rotate. Operands that a later step still needs travel forward in the same pipeline registers. As a result, a fresh, unrelated input set can enter on every clock.

The block is meant to be tiled. Several copies sit side by side to cover a full state vector, and chains of them form an unrolled round sequence. Selecting the message words, permuting words between rounds and finalising the hash all happen outside this block. A valid flag rides with the data, so the consumer can tell real results from pipeline bubbles. A synchronous reset clears only the valid flags. The data registers keep whatever they held and carry no reset.

Top module: `gmix_pipe`

## Requirements
- R1: Every state and message word is 64 bits wide. All additions wrap modulo 2^64, so carries out of bit 63 are discarded.
- R2: A result leaves exactly 4 clock edges after its inputs are sampled. An input sampled at rising edge N has `out_valid` high, with its result on the output words, after rising edge N+3.
- R3: A new, independent input set is accepted on every clock with `in_valid` high. Back-to-back results appear on consecutive cycles, with no stall and no mixing between neighbours.
- R4: The four steps run in this fixed order. Step one: a = a + b + x, then d = (d XOR a) rotated right by 32. Step two: c = c + d, then b = (b XOR c) rotated right by 24. Step three: a = a + b + y, then d = (d XOR a) rotated right by 16. Step four: c = c + d, then b = (b XOR c) rotated right by 63. Each step uses the values updated by the steps before it. The outputs are the final a, b, c and d.
- R5: Word x is consumed only in step one and word y only in step three. Swapping x and y therefore changes the result in general.
- R6: While `rst` is high, and in the cycles after it until a new valid input has crossed all four stages, `out_valid` stays low. Inputs that were in flight when reset was applied never emerge as valid.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low 4 clocks later. The data presented in that bubble does not alter any valid result before or after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears valid flags only |
| in_valid | input | 1 | Input word set is valid this cycle |
| in_a | input | 64 | State word a |
| in_b | input | 64 | State word b |
| in_c | input | 64 | State word c |
| in_d | input | 64 | State word d |
| in_x | input | 64 | First message word (step one) |
| in_y | input | 64 | Second message word (step three) |
| out_valid | output | 1 | Result words are valid this cycle |
| out_a | output | 64 | Mixed word a |
| out_b | output | 64 | Mixed word b |
| out_c | output | 64 | Mixed word c |
| out_d | output | 64 | Mixed word d |

## Verification
Because every register feeds the next without feedback, a fault inside the pipeline shows up at the ports on the very input set that crosses it, 4 clocks after entry. A wrong rotation amount, a swapped operand or a missing carry corrupts that one result word. A broken pass-through register makes the words of two neighbouring inputs bleed into each other on back-to-back traffic. A valid flag that is dropped, delayed or not cleared shows at once: results come out missing, late or spurious against the scoreboard's expected arrival cycle. Such a flag fault stays visible until reset or the next bubble.

// File: rtl/gmix_pkg.sv
package gmix_pkg;

    localparam int WORD_W = 64;
    localparam int STEPS  = 4;

    typedef logic [WORD_W-1:0] word_t;

    // State words plus the message words still to be consumed:
    // m_now feeds the next a-update, m_later waits for the one after it.
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t m_now;
        word_t m_later;
    } mix_bus_t;

    function automatic word_t rotr(word_t v, int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // Rotation for each step, in pipeline order.
    function automatic int unsigned step_rot(int idx);
        case (idx)
            0:       return 32;
            1:       return 24;
            2:       return 16;
            default: return 63;
        endcase
    endfunction

endpackage

// File: rtl/gmix_step.sv
module gmix_step
    import gmix_pkg::*;
#(
    parameter bit          A_STEP = 1'b1,
    parameter int unsigned ROT    = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_vld,
    input  mix_bus_t in_bus,
    output logic     out_vld,
    output mix_bus_t out_bus
);

    typedef struct packed {
        logic     vld;
        mix_bus_t bus;
    } step_state_t;

    step_state_t state_d, state_q;
    mix_bus_t    upd_bus;

    generate
        if (A_STEP) begin : g_a_update
            word_t sum_a;
            always_comb begin
                upd_bus       = in_bus;
                sum_a         = in_bus.a + in_bus.b + in_bus.m_now;
                upd_bus.a     = sum_a;
                upd_bus.d     = rotr(in_bus.d ^ sum_a, ROT);
                upd_bus.m_now = in_bus.m_later;
            end
        end else begin : g_c_update
            word_t sum_c;
            always_comb begin
                upd_bus   = in_bus;
                sum_c     = in_bus.c + in_bus.d;
                upd_bus.c = sum_c;
                upd_bus.b = rotr(in_bus.b ^ sum_c, ROT);
            end
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_vld;
        state_d.bus = upd_bus;
    end

    always_ff @(posedge clk) begin
        state_q.bus <= state_d.bus;
        if (rst) state_q.vld <= 1'b0;
        else     state_q.vld <= state_d.vld;
    end

    assign out_vld = state_q.vld;
    assign out_bus = state_q.bus;

    // R2: the flag advances exactly one stage per clock
    p_vld_advance_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_vld == $past(in_vld)));

    generate
        if (A_STEP) begin : g_a_checks
            // R4: an a-update leaves b and c untouched
            p_a_step_keeps_bc_r4: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vld)) |->
                    (out_bus.b == $past(in_bus.b) && out_bus.c == $past(in_bus.c)));
            // R5: the later message word moves up to be consumed next
            p_msg_shift_r5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vld)) |-> (out_bus.m_now == $past(in_bus.m_later)));
        end else begin : g_c_checks
            // R4: a c-update leaves a and d untouched
            p_c_step_keeps_ad_r4: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vld)) |->
                    (out_bus.a == $past(in_bus.a) && out_bus.d == $past(in_bus.d)));
        end
    endgenerate

endmodule

// File: rtl/gmix_pipe.sv
module gmix_pipe
    import gmix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_a,
    input  logic [63:0] in_b,
    input  logic [63:0] in_c,
    input  logic [63:0] in_d,
    input  logic [63:0] in_x,
    input  logic [63:0] in_y,
    output logic        out_valid,
    output logic [63:0] out_a,
    output logic [63:0] out_b,
    output logic [63:0] out_c,
    output logic [63:0] out_d
);

    localparam int CNT_W = $clog2(STEPS + 1);

    logic     stage_vld [STEPS+1];
    mix_bus_t stage_bus [STEPS+1];

    always_comb begin
        stage_vld[0]         = in_valid;
        stage_bus[0].a       = in_a;
        stage_bus[0].b       = in_b;
        stage_bus[0].c       = in_c;
        stage_bus[0].d       = in_d;
        stage_bus[0].m_now   = in_x;
        stage_bus[0].m_later = in_y;
    end

    generate
        for (genvar s = 0; s < STEPS; s++) begin : g_step
            gmix_step #(
                .A_STEP ((s % 2) == 0),
                .ROT    (step_rot(s))
            ) u_step (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (stage_vld[s]),
                .in_bus  (stage_bus[s]),
                .out_vld (stage_vld[s+1]),
                .out_bus (stage_bus[s+1])
            );
        end
    endgenerate

    assign out_valid = stage_vld[STEPS];
    assign out_a     = stage_bus[STEPS].a;
    assign out_b     = stage_bus[STEPS].b;
    assign out_c     = stage_bus[STEPS].c;
    assign out_d     = stage_bus[STEPS].d;

    // Cycles since reset release, saturating at the pipeline depth (assertion support)
    logic [CNT_W-1:0] since_rst_d, since_rst_q;

    always_comb begin
        since_rst_d = since_rst_q;
        if (since_rst_q != CNT_W'(STEPS)) since_rst_d = since_rst_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) since_rst_q <= '0;
        else     since_rst_q <= since_rst_d;
    end

    // R2: the flag at the output is the input flag from four edges earlier
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == CNT_W'(STEPS)) |-> (out_valid == $past(in_valid, 4)));

    // R6: nothing valid emerges right after reset
    p_idle_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    // R7: a bubble can only leave if a bubble went in
    p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == CNT_W'(STEPS) && !$past(in_valid, 4)) |-> !out_valid);

endmodule

// File: tb/tb_gmix_pipe.sv
module tb_gmix_pipe;
    import gmix_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    typedef struct {
        word_t a, b, c, d;
        int    issue;
    } exp_t;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  in_valid = 1'b0;
    word_t in_a = '0, in_b = '0, in_c = '0, in_d = '0, in_x = '0, in_y = '0;
    logic  out_valid;
    word_t out_a, out_b, out_c, out_d;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    exp_t  sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gmix_pipe dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
    );

    function automatic word_t ror(word_t v, int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    // Reference model written from R1 and R4
    function automatic exp_t g_model(word_t a, word_t b, word_t c, word_t d, word_t x, word_t y);
        exp_t e;
        a = a + b + x;  d = ror(d ^ a, 32);
        c = c + d;      b = ror(b ^ c, 24);
        a = a + b + y;  d = ror(d ^ a, 16);
        c = c + d;      b = ror(b ^ c, 63);
        e.a = a; e.b = b; e.c = c; e.d = d; e.issue = 0;
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, word_t act, word_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(bit v, word_t a, word_t b, word_t c, word_t d, word_t x, word_t y);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b; in_c = c; in_d = d; in_x = x; in_y = y;
        if (v) begin
            e = g_model(a, b, c, d, x, y);
            e.issue = cyc;
            sb.push_back(e);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected valid", 64'(out_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc - e.issue == LAT, "R2", "latency", 64'(cyc - e.issue), 64'(LAT));
                    check(out_a == e.a, "R4", "word a", out_a, e.a);
                    check(out_b == e.b, "R4", "word b", out_b, e.b);
                    check(out_c == e.c, "R4", "word c", out_c, e.c);
                    check(out_d == e.d, "R4", "word d", out_d, e.d);
                end
            end else if (sb.size() != 0 && sb[0].issue + LAT <= cyc) begin
                check(1'b0, "R3", "missing result", 64'd0, 64'd1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        exp_t r_xy, r_yx;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6", "valid during reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6", "valid after reset, no input", 64'(out_valid), 64'd0);
        end

        // R4: single transfers with simple patterns
        drive(1'b1, 0, 0, 0, 0, 0, 0);
        drive(1'b1, 64'h1, 64'h2, 64'h3, 64'h4, 64'h5, 64'h6);
        idle(6);

        // R1: carries out of bit 63 are dropped
        drive(1'b1, '1, '1, '1, '1, '1, '1);
        drive(1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, '1, 64'h1, '1, 64'h8000_0000_0000_0001);
        idle(6);

        // R5: swapping x and y changes the result
        r_xy = g_model(64'h0123_4567_89ab_cdef, 64'h1111, 64'h2222, 64'h3333, 64'hdead_beef, 64'h0);
        r_yx = g_model(64'h0123_4567_89ab_cdef, 64'h1111, 64'h2222, 64'h3333, 64'h0, 64'hdead_beef);
        check(r_xy.a != r_yx.a, "R5", "model sanity x/y order", r_xy.a, r_yx.a);
        drive(1'b1, 64'h0123_4567_89ab_cdef, 64'h1111, 64'h2222, 64'h3333, 64'hdead_beef, 64'h0);
        drive(1'b1, 64'h0123_4567_89ab_cdef, 64'h1111, 64'h2222, 64'h3333, 64'h0, 64'hdead_beef);
        drive(1'b1, 0, 0, 0, 0, 64'h0, 64'h1);
        drive(1'b1, 0, 0, 0, 0, 64'h1, 64'h0);
        idle(6);

        // R3: long back-to-back burst of random inputs
        for (int i = 0; i < 200; i++)
            drive(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});

        // R7: random bubbles with random junk data
        for (int i = 0; i < 200; i++) begin
            bit v;
            v = ($urandom % 3) != 0;
            drive(v, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        end
        idle(8);

        // R6: reset with data in flight drops it
        drive(1'b1, 64'h5, 64'h6, 64'h7, 64'h8, 64'h9, 64'ha);
        drive(1'b1, 64'h15, 64'h16, 64'h17, 64'h18, 64'h19, 64'h1a);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        sb.delete();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6", "in-flight data after reset", 64'(out_valid), 64'd0);
        end

        // Traffic resumes correctly after reset (R2, R4)
        drive(1'b1, 64'hface, 64'hb00c, 64'hcafe, 64'hfeed, 64'h1234, 64'h5678);
        idle(8);
        check(sb.size() == 0, "R3", "results outstanding", 64'(sb.size()), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule